// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block picks the link configuration that a serial display link should try to train. A start pulse captures the payload data rate and the capabilities of the two ends. The block then settles on a lane count and a per-lane rate. It first looks for the fewest lanes that carry the payload at the fastest usable rate. It then lowers the rate as far as that lane count still allows. When the configuration is ready it presents the per-lane rate, the rate code to write to the sink, and the lane-count byte to write to the sink. The lane-count byte carries the enhanced-framing flag when the sink supports it.

Link training runs outside this block. Each time a training attempt fails, a pulse on the fail input makes the block step down one rate. It then repeats the lane and rate choice from the full lane budget. When no lower rate remains, the block raises its exhausted output and stays there until the next start pulse.

No division sits in the selection path. The rates are stored as small codes and expanded by a constant multiply. The scaled bandwidth is formed by a shift and a constant multiply. Each step of the search is a registered compare, taking one clock per step.

Top module: `link_sel`

## Requirements
- R1: After reset, cfg_valid and exhausted are 0 and lane_count, lane_rate, rate_code and lane_byte are all 0; cfg_valid and exhausted are never both 1.
- R2: On start, the effective lane limit is the smaller of enc_max_lanes and bits 4:0 of sink_lane_byte. The effective rate limit is the smaller of enc_max_rate and sink_rate_code times 27000.
- R3: The rate list is 270000 then 162000 (units of 10 kbit/s). The first rate tried is the first list entry not above the effective rate limit. If no entry qualifies, exhausted is raised. While cfg_valid is 1, lane_rate is nonzero.
- R4: Starting from the effective lane limit, the lane count is halved (integer shift) while half of it times the current rate is strictly greater than the required bandwidth.
- R5: With the lane count fixed, the rate moves to the next list entry while that entry times the lane count is strictly greater than the required bandwidth.
- R6: The required bandwidth is (data_rate / 8) * 10. The division truncates and comes before the multiply.
- R7: rate_code equals lane_rate / 27000, giving 10 for 270000 and 6 for 162000. lane_byte holds the lane count in bits 4:0, zeros in bits 6:5, and sink_enh_cap (as captured at start) in bit 7.
- R8: A train_fail pulse while cfg_valid is 1 drops cfg_valid on the next clock. The block then advances one rate and repeats R4 and R5 from the full lane limit. If the list is used up, it raises exhausted instead. Without train_fail or start, a valid configuration holds unchanged.
- R9: train_fail has no effect while cfg_valid is 0. In particular, exhausted stays 1.
- R10: start restarts the selection from any state. On the next clock, cfg_valid and exhausted are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture inputs and begin a selection |
| data_rate | input | 32 | Payload data rate, 10 kbit/s units |
| enc_max_lanes | input | 5 | Source lane limit |
| enc_max_rate | input | 20 | Source per-lane rate limit |
| sink_rate_code | input | 8 | Sink maximum rate as a multiple of 27000 |
| sink_lane_byte | input | 8 | Sink lane capability byte, lanes in bits 4:0 |
| sink_enh_cap | input | 1 | Sink supports enhanced framing |
| train_fail | input | 1 | Pulse: the current configuration failed training |
| cfg_valid | output | 1 | A configuration is presented |
| lane_count | output | 5 | Selected lane count |
| lane_rate | output | 20 | Selected per-lane rate |
| rate_code | output | 8 | Rate code to write to the sink |
| lane_byte | output | 8 | Lane-count byte to write to the sink |
| exhausted | output | 1 | No configuration remains |

## Verification
The bench builds the block with its default parameters: a 32-bit data rate, 5-bit lane counts and the two-entry rate list. These values reach every search outcome.

The stimuli place the required bandwidth exactly on and just below a rate boundary, so the strict compares of R4 and R5 are exercised. They also let either end set the limits, cap the rate below the whole list, and walk a configuration through every fallback to exhaustion. Finally, they send fail pulses while no configuration is presented.

// File: rtl/lsel_pkg.sv
// Package for the link rate and lane selector.
// It holds the shared widths, the rate list kept as small multiples of the
// unit step, and the sequencer states.
package lsel_pkg;
    localparam int RATE_W    = 20;
    localparam int LANE_W    = 5;
    localparam int CODE_W    = 8;
    localparam int NUM_RATES = 2;
    localparam int UNIT_STEP = 27000;
    localparam int IDX_W     = $clog2(NUM_RATES + 2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_LANES,
        ST_DROP,
        ST_READY,
        ST_DONE
    } lsel_state_e;

    // Rate list in descending order, as multiples of UNIT_STEP; 0 ends the list.
    function automatic logic [CODE_W-1:0] code_at(input int unsigned i);
        case (i)
            0:       code_at = CODE_W'(10);
            1:       code_at = CODE_W'(6);
            default: code_at = '0;
        endcase
    endfunction
endpackage

// File: rtl/lsel_rate_rom.sv
// Rate list lookup.
// Maps a list index to a rate code and to the rate in 10 kbit/s units,
// using a constant multiply. An index past the end of the list returns 0.
module lsel_rate_rom
    import lsel_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int RW = RATE_W,
    parameter int CW = CODE_W
) (
    input  logic [IW-1:0] idx,
    output logic [CW-1:0] code,
    output logic [RW-1:0] rate
);
    // Decode the code and expand it to a rate.
    always_comb begin
        code = code_at(int'(idx));
        rate = RW'(code * UNIT_STEP);
    end
endmodule

// File: rtl/lsel_limits.sv
// Capture of the limits at start.
// On start it registers the required bandwidth, (rate/8)*10, and the
// effective lane and rate limits (the smaller of source and sink), together
// with the enhanced-framing flag. It assumes the inputs are valid in the
// start cycle only.
module lsel_limits
    import lsel_pkg::*;
#(
    parameter int DR_W = 32,
    parameter int LW   = LANE_W,
    parameter int RW   = RATE_W,
    parameter int CW   = CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DR_W-1:0] data_rate,
    input  logic [LW-1:0]   enc_max_lanes,
    input  logic [RW-1:0]   enc_max_rate,
    input  logic [CW-1:0]   sink_rate_code,
    input  logic [7:0]      sink_lane_byte,
    input  logic            sink_enh_cap,
    output logic [DR_W:0]   req_bw,
    output logic [LW-1:0]   max_lanes,
    output logic [RW-1:0]   max_rate,
    output logic            enh
);
    localparam int SR_W = CW + 15;

    logic [DR_W:0]  bw_next;
    logic [SR_W-1:0] sink_rate;
    logic [LW-1:0]  sink_lanes;

    // Scale the bandwidth by 10/8 and take the smaller of each limit pair.
    always_comb begin
        bw_next    = (DR_W+1)'(data_rate >> 3) * (DR_W+1)'(10);
        sink_rate  = SR_W'(sink_rate_code) * SR_W'(UNIT_STEP);
        sink_lanes = LW'(sink_lane_byte[4:0]);
    end

    // Register the limits when a selection starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_bw    <= '0;
            max_lanes <= '0;
            max_rate  <= '0;
            enh       <= 1'b0;
        end else if (start) begin
            req_bw    <= bw_next;
            max_lanes <= (sink_lanes < enc_max_lanes) ? sink_lanes : enc_max_lanes;
            max_rate  <= (sink_rate < SR_W'(enc_max_rate)) ? RW'(sink_rate) : enc_max_rate;
            enh       <= sink_enh_cap;
        end
    end
endmodule

// File: rtl/lsel_seq.sv
// Selection sequencer.
// It skips the rates above the limit, halves the lane count while fewer
// lanes suffice, then moves down the rate list while the lane count allows.
// Each step takes one clock. A fail pulse in READY advances one rate and
// searches again. start has priority in every state.
module lsel_seq
    import lsel_pkg::*;
#(
    parameter int DR_W = 32,
    parameter int LW   = LANE_W,
    parameter int RW   = RATE_W,
    parameter int IW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          train_fail,
    input  logic [DR_W:0] req_bw,
    input  logic [LW-1:0] max_lanes,
    input  logic [RW-1:0] max_rate,
    input  logic [RW-1:0] cur_rate,
    input  logic [RW-1:0] nxt_rate,
    output lsel_state_e   state,
    output logic [IW-1:0] idx,
    output logic [LW-1:0] lanes
);
    localparam int PW = DR_W + 1;

    logic [PW-1:0] half_prod;
    logic [PW-1:0] next_prod;

    // Bandwidth of half the lanes at this rate, and of all lanes at the next rate.
    always_comb begin
        half_prod = PW'(cur_rate) * PW'(lanes >> 1);
        next_prod = PW'(nxt_rate) * PW'(lanes);
    end

    // Step the search one compare per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            lanes <= '0;
        end else if (start) begin
            state <= ST_SEEK;
            idx   <= '0;
        end else begin
            case (state)
                ST_SEEK: begin
                    if (cur_rate == '0) begin
                        state <= ST_DONE;
                    end else if (cur_rate > max_rate) begin
                        idx <= idx + 1'b1;
                    end else begin
                        lanes <= max_lanes;
                        state <= ST_LANES;
                    end
                end
                ST_LANES: begin
                    if (half_prod > req_bw) lanes <= lanes >> 1;
                    else                    state <= ST_DROP;
                end
                ST_DROP: begin
                    if (next_prod > req_bw) idx   <= idx + 1'b1;
                    else                    state <= ST_READY;
                end
                ST_READY: begin
                    if (train_fail) begin
                        idx   <= idx + 1'b1;
                        state <= ST_SEEK;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/link_sel.sv
// Top level of the link rate and lane selector.
// It ties together the limit capture, the sequencer and two rate lookups
// (one for the current index, one for the next). The outputs are zero
// unless a configuration is presented.
module link_sel
    import lsel_pkg::*;
#(
    parameter int DR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DR_W-1:0]   data_rate,
    input  logic [LANE_W-1:0] enc_max_lanes,
    input  logic [RATE_W-1:0] enc_max_rate,
    input  logic [CODE_W-1:0] sink_rate_code,
    input  logic [7:0]        sink_lane_byte,
    input  logic              sink_enh_cap,
    input  logic              train_fail,
    output logic              cfg_valid,
    output logic [LANE_W-1:0] lane_count,
    output logic [RATE_W-1:0] lane_rate,
    output logic [CODE_W-1:0] rate_code,
    output logic [7:0]        lane_byte,
    output logic              exhausted
);
    logic [DR_W:0]       req_bw;
    logic [LANE_W-1:0]   max_lanes;
    logic [RATE_W-1:0]   max_rate;
    logic                enh;
    lsel_state_e         state;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    idx_nxt;
    logic [LANE_W-1:0]   lanes;
    logic [CODE_W-1:0]   cur_code;
    logic [CODE_W-1:0]   nxt_code;
    logic [RATE_W-1:0]   cur_rate;
    logic [RATE_W-1:0]   nxt_rate;

    assign idx_nxt = idx + 1'b1;

    lsel_limits #(.DR_W(DR_W)) u_limits (
        .clk(clk), .rst_n(rst_n), .start(start), .data_rate(data_rate),
        .enc_max_lanes(enc_max_lanes), .enc_max_rate(enc_max_rate),
        .sink_rate_code(sink_rate_code), .sink_lane_byte(sink_lane_byte),
        .sink_enh_cap(sink_enh_cap), .req_bw(req_bw), .max_lanes(max_lanes),
        .max_rate(max_rate), .enh(enh)
    );

    lsel_rate_rom u_rom_cur (.idx(idx),     .code(cur_code), .rate(cur_rate));
    lsel_rate_rom u_rom_nxt (.idx(idx_nxt), .code(nxt_code), .rate(nxt_rate));

    lsel_seq #(.DR_W(DR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .train_fail(train_fail),
        .req_bw(req_bw), .max_lanes(max_lanes), .max_rate(max_rate),
        .cur_rate(cur_rate), .nxt_rate(nxt_rate), .state(state),
        .idx(idx), .lanes(lanes)
    );

    // Present the configuration only while it is ready.
    always_comb begin
        cfg_valid  = (state == ST_READY);
        exhausted  = (state == ST_DONE);
        lane_count = cfg_valid ? lanes    : '0;
        lane_rate  = cfg_valid ? cur_rate : '0;
        rate_code  = cfg_valid ? cur_code : '0;
        lane_byte  = cfg_valid ? {enh, (7-LANE_W)'(0), lanes} : 8'h00;
    end

    logic unused_nxt;
    assign unused_nxt = ^nxt_code;
endmodule

// File: rtl/lsel_chk.sv
// Assertion checker for link_sel, attached with bind.
// It relates the handshake inputs to the presented state over time.
module lsel_chk
    import lsel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              train_fail,
    input logic              cfg_valid,
    input logic              exhausted,
    input logic [LANE_W-1:0] lane_count,
    input logic [RATE_W-1:0] lane_rate
);
    // R1
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && exhausted));
    // R3
    rate_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> lane_rate != '0);
    // R8
    fail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && train_fail && !start |=> !cfg_valid);
    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !train_fail && !start |=>
            cfg_valid && $stable(lane_count) && $stable(lane_rate));
    // R9
    exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted && !start |=> exhausted);
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !cfg_valid && !exhausted);
endmodule

bind link_sel lsel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .train_fail(train_fail),
    .cfg_valid(cfg_valid), .exhausted(exhausted),
    .lane_count(lane_count), .lane_rate(lane_rate)
);

// File: tb/link_sel_bench.sv
// Self-checking bench for link_sel with a behavioural reference model.
module link_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] data_rate = '0;
    logic [4:0]  enc_max_lanes = '0;
    logic [19:0] enc_max_rate = '0;
    logic [7:0]  sink_rate_code = '0;
    logic [7:0]  sink_lane_byte = '0;
    logic        sink_enh_cap = 1'b0;
    logic        train_fail = 1'b0;
    logic        cfg_valid, exhausted;
    logic [4:0]  lane_count;
    logic [19:0] lane_rate;
    logic [7:0]  rate_code, lane_byte;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit e_val, e_exh;
    int e_lanes, e_rate, e_code, e_byte;
    string e_tag = "";

    always #10 clk = ~clk;

    link_sel u_link_sel (.*);

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference: outcome after k failed attempts.
    task automatic ref_sel(input longint dr, input int el, input longint er, input int sc,
                           input int slb, input int enh, input int k);
        longint rl[3] = '{270000, 162000, 0};
        longint req, mr;
        int ml, i, ln;
        req = (dr / 8) * 10;
        ml  = ((slb & 31) < el) ? (slb & 31) : el;
        mr  = (sc * 27000 < er) ? sc * 27000 : er;
        i = 0;
        while (rl[i] != 0 && rl[i] > mr) i++;
        e_exh = 1'b0; ln = 0;
        for (int a = 0; a <= k; a++) begin
            if (rl[i] == 0) begin e_exh = 1'b1; break; end
            ln = ml;
            while ((ln >> 1) * rl[i] > req) ln = ln >> 1;
            while (rl[i+1] * ln > req) i++;
            if (a < k) i++;
        end
        e_val   = !e_exh;
        e_lanes = e_exh ? 0 : ln;
        e_rate  = e_exh ? 0 : int'(rl[i]);
        e_code  = e_rate / 27000;
        e_byte  = e_exh ? 0 : ((enh << 7) | ln);
    endtask

    // Compare every clock while an expectation is armed.
    always @(negedge clk) begin
        if (armed) begin
            check(e_tag, "cfg_valid", cfg_valid, e_val);
            check(e_tag, "exhausted", exhausted, e_exh);
            check(e_tag, "lane_count", lane_count, e_lanes);
            check(e_tag, "lane_rate", lane_rate, e_rate);
            check(e_tag, "rate_code", rate_code, e_code);
            check(e_tag, "lane_byte", lane_byte, e_byte);
        end
    end

    task automatic settle(input string tag);
        int n = 0;
        while (!(cfg_valid || exhausted) && n < 64) begin @(negedge clk); n++; end
        check(tag, "settle_timeout", (n >= 64) ? 1 : 0, 0);
        e_tag = tag;
        armed = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input string tag, input longint dr, input int el, input longint er,
                       input int sc, input int slb, input int enh, input int fails);
        armed = 1'b0;
        data_rate = 32'(dr); enc_max_lanes = 5'(el); enc_max_rate = 20'(er);
        sink_rate_code = 8'(sc); sink_lane_byte = 8'(slb); sink_enh_cap = enh[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        data_rate = '1; sink_lane_byte = 8'h1F; sink_enh_cap = ~enh[0];
        check(tag, "restart_clear", {cfg_valid, exhausted}, 0);
        ref_sel(dr, el, er, sc, slb, enh, 0);
        settle(tag);
        for (int f = 1; f <= fails; f++) begin
            armed = 1'b0;
            train_fail = 1'b1;
            @(negedge clk);
            train_fail = 1'b0;
            ref_sel(dr, el, er, sc, slb, enh, f);
            settle(tag);
        end
    endtask

    task automatic main;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", "valid", cfg_valid, 0);
        check("R1", "exh", exhausted, 0);
        check("R1", "outs", {lane_count, lane_rate, rate_code, lane_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: fail pulse while idle has no effect
        train_fail = 1'b1; @(negedge clk); train_fail = 1'b0; @(negedge clk);
        check("R9", "idle_fail", {cfg_valid, exhausted}, 0);
        run("R7_full", 1000000, 4, 270000, 10, 8'h84, 1, 0);
        run("R4_R5_one", 80000, 4, 270000, 10, 4, 0, 0);
        run("R8_walk", 300000, 4, 270000, 10, 4, 1, 2);
        // R9: fail while exhausted keeps exhausted
        armed = 1'b0;
        train_fail = 1'b1; @(negedge clk); train_fail = 1'b0;
        armed = 1'b1; e_tag = "R9";
        repeat (3) @(negedge clk);
        run("R2_limits", 1000000, 2, 200000, 10, 8'hE4, 0, 1);
        run("R3_sinkcap", 400000, 4, 270000, 6, 4, 1, 1);
        run("R3_none", 1000, 4, 100000, 10, 4, 0, 0);
        run("R6_edge_on", 129600, 4, 270000, 10, 4, 0, 0);
        run("R6_edge_below", 129592, 4, 270000, 10, 4, 0, 0);
        run("R2_sinklanes", 1000000, 8, 270000, 10, 8'h61, 1, 0);
        // R10: restart from a valid configuration
        run("R10_restart", 2000000, 4, 270000, 10, 2, 0, 0);
        armed = 1'b0;
    endtask

    initial begin
        fork
            main();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule